// File: doc/BRIEF.md
# Calibrating Converter Control Sequencer

This block is the clocked control core of a successive-approximation converter that can run a full self-calibration and an optional auto-zero step. It watches active-low chip-select, write, sample/hold and calibrate strobes, plus an auto-zero request level. From these it sequences the calibration phases, the auto-zero phase, the acquisition window and the bit-by-bit approximation loop. The analog parts are outside the block. Its only input from them is one comparator decision bit per clock. It drives a 13-bit trial code that an external DAC converts.

There are two ways to start a conversion. In the first, a write strobe starts it and the block times the acquisition window itself. In the second, a sample/hold strobe opens the window and holds it open until the strobe is released. Calibration can be requested at any time and overrides whatever is running.

The state machine has eight states:
- `S_IDLE`: waiting, with the sampler tracking.
- `S_CAL_OFS`: offset measurement.
- `S_CAL_DAC`: DAC mismatch measurement.
- `S_AUTOZERO`: auto-zero.
- `S_ACQ_TIMED`: acquisition with an internal timer.
- `S_ACQ_HELD`: acquisition held open by the sample/hold strobe.
- `S_CONVERT`: the bit loop.
- `S_DONE`: result strobe.

It has these transitions:
- any state to `S_CAL_OFS` on a calibrate falling edge
- `S_CAL_OFS` to `S_CAL_DAC`, and `S_CAL_DAC` to `S_IDLE`, when their timers expire
- `S_IDLE` to `S_AUTOZERO` (write start with auto-zero requested)
- `S_IDLE` to `S_ACQ_TIMED` (write start without auto-zero)
- `S_IDLE` to `S_ACQ_HELD` (sample/hold falling edge)
- `S_AUTOZERO` to `S_ACQ_TIMED` when its timer expires
- `S_ACQ_TIMED` to `S_CONVERT` when its timer expires
- `S_ACQ_HELD` to `S_CONVERT` (sample/hold rising edge)
- `S_CONVERT` to `S_DONE` after the last bit
- `S_DONE` to `S_IDLE`

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset the block has `eoc`=1, `sample_en`=1, `res_valid`=0, `az_phase`=0, `cal_ofs_phase`=0, `cal_dac_phase`=0 and `sar`=0.
- R2: A falling edge on `cal_n` abandons any activity, clears `sar` to 0 and holds `eoc` low for exactly 1399 clocks. `eoc` then returns high and no `res_valid` pulse is produced.
- R3: Calibration runs the offset phase first, with `cal_ofs_phase` high for 199 clocks. The mismatch phase follows, with `cal_dac_phase` high for the remaining 1200 clocks. At most one of the phase indicators is high at a time.
- R4: A rising edge on `wr_n` starts a conversion only while `cs_n` is low. With `cs_n` high, strobes on `wr_n` and `sh_n` change nothing at the outputs.
- R5: A write start with `az_n` low gives 26 clocks of `az_phase`, then 7 clocks of `sample_en`. `eoc` stays high through both, and `sample_en` is low during auto-zero.
- R6: A write start with `az_n` high keeps the acquisition window that has been open in idle (`sample_en`=1) for 7 more clocks. Conversion follows, with no auto-zero.
- R7: With `cs_n` low, a falling edge on `sh_n` opens acquisition (`sample_en`=1, `eoc`=1) for as long as `sh_n` stays low. The next rising edge starts conversion.
- R8: Conversion holds `eoc` low with `sample_en` low for 14 clocks: 13 bit clocks and one result clock.
- R9: The loop resolves 13 bits MSB first. Each clock it keeps the trial bit if `cmp_in`=1 and clears it if `cmp_in`=0, then sets the next lower bit. With a comparator that reports `sar` <= V, the result equals V for every 13-bit unsigned V.
- R10: `res_valid` is high for exactly one clock, the last clock of low `eoc`, with the final code on `sar`. `eoc` is high on the next clock, and `sar` holds its value while `eoc` stays high.
- R11: Write and sample/hold strobes arriving during auto-zero, acquisition, conversion or calibration are ignored. The running sequence keeps its length and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; its rising edge starts a conversion |
| sh_n | input | 1 | Sample/hold strobe; low opens acquisition |
| cal_n | input | 1 | Calibrate; its falling edge starts calibration |
| az_n | input | 1 | Auto-zero request, active low, sampled at the write start |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| eoc | output | 1 | High when idle or acquiring; low when converting or calibrating |
| sample_en | output | 1 | Acquisition window open |
| az_phase | output | 1 | Auto-zero phase active |
| cal_ofs_phase | output | 1 | Calibration offset phase active |
| cal_dac_phase | output | 1 | Calibration mismatch phase active |
| sar | output | 13 | Trial and result code |
| res_valid | output | 1 | One-clock strobe marking the final result |

## Verification
A state register that lands in the wrong state shows up at once as the wrong combination of `eoc`, `sample_en` and the phase indicators, at the first clock after the faulty edge. A timer that is loaded wrongly, or a miscounted bit loop, changes the number of clocks that `eoc` stays low or a phase indicator stays high, so each sequence length is counted exactly. A wrong keep/clear decision or a wrong mask shift in the bit loop corrupts the code shown with `res_valid`. A sweep over many input codes, including both ends of the range, exposes that fault within one conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CAL_OFS,
        S_CAL_DAC,
        S_AUTOZERO,
        S_ACQ_TIMED,
        S_ACQ_HELD,
        S_CONVERT,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/adcseq_edge_reg.sv
module adcseq_edge_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] prev_n
);
    for (genvar i = 0; i < N; i++) begin : g_prev
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_n[i] <= 1'b1;
            else        prev_n[i] <= strobe_n[i];
        end
    end
endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] code,
    output logic         last_bit
);
    localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            mask <= '0;
        end else if (clr) begin
            code <= '0;
            mask <= '0;
        end else if (start) begin
            code <= MSB;
            mask <= MSB;
        end else if (step) begin
            code <= (cmp ? code : (code & ~mask)) | (mask >> 1);
            mask <= mask >> 1;
        end
    end

    assign last_bit = mask[0];
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int SAR_W       = 13,
    parameter int CAL_TOTAL   = 1399,
    parameter int CAL_OFS_LEN = 199,
    parameter int AZ_LEN      = 26,
    parameter int ACQ_LEN     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             sh_n,
    input  logic             cal_n,
    input  logic             az_n,
    input  logic             cmp_in,
    output logic             eoc,
    output logic             sample_en,
    output logic             az_phase,
    output logic             cal_ofs_phase,
    output logic             cal_dac_phase,
    output logic [SAR_W-1:0] sar,
    output logic             res_valid
);
    localparam int CAL_DAC_LEN = CAL_TOTAL - CAL_OFS_LEN;
    localparam int MAX_LEN     = (CAL_DAC_LEN > CAL_OFS_LEN) ? CAL_DAC_LEN : CAL_OFS_LEN;
    localparam int CNT_W       = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] LD_OFS = CNT_W'(CAL_OFS_LEN - 1);
    localparam logic [CNT_W-1:0] LD_DAC = CNT_W'(CAL_DAC_LEN - 1);
    localparam logic [CNT_W-1:0] LD_AZ  = CNT_W'(AZ_LEN - 1);
    localparam logic [CNT_W-1:0] LD_ACQ = CNT_W'(ACQ_LEN - 1);

    seq_state_t       st, st_nxt;
    logic [2:0]       prev_n;
    logic             wr_go, sh_open, sh_close, cal_go;
    logic             tmr_load, tmr_done, sar_start, last_bit;
    logic [CNT_W-1:0] tmr_val;

    adcseq_edge_reg #(.N(3)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({cal_n, sh_n, wr_n}),
        .prev_n   (prev_n)
    );

    assign wr_go    = ~cs_n &  wr_n  & ~prev_n[0];
    assign sh_open  = ~cs_n & ~sh_n  &  prev_n[1];
    assign sh_close = ~cs_n &  sh_n  & ~prev_n[1];
    assign cal_go   = ~cal_n & prev_n[2];

    adcseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    adcseq_sar #(.W(SAR_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cal_go),
        .start    (sar_start),
        .step     (st == S_CONVERT),
        .cmp      (cmp_in),
        .code     (sar),
        .last_bit (last_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt    = st;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sar_start = 1'b0;
        if (cal_go) begin
            st_nxt   = S_CAL_OFS;
            tmr_load = 1'b1;
            tmr_val  = LD_OFS;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (wr_go && !az_n) begin
                        st_nxt   = S_AUTOZERO;
                        tmr_load = 1'b1;
                        tmr_val  = LD_AZ;
                    end else if (wr_go) begin
                        st_nxt   = S_ACQ_TIMED;
                        tmr_load = 1'b1;
                        tmr_val  = LD_ACQ;
                    end else if (sh_open) begin
                        st_nxt = S_ACQ_HELD;
                    end
                end
                S_CAL_OFS: if (tmr_done) begin
                    st_nxt   = S_CAL_DAC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_DAC;
                end
                S_CAL_DAC: if (tmr_done) st_nxt = S_IDLE;
                S_AUTOZERO: if (tmr_done) begin
                    st_nxt   = S_ACQ_TIMED;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACQ;
                end
                S_ACQ_TIMED: if (tmr_done) begin
                    st_nxt    = S_CONVERT;
                    sar_start = 1'b1;
                end
                S_ACQ_HELD: if (sh_close) begin
                    st_nxt    = S_CONVERT;
                    sar_start = 1'b1;
                end
                S_CONVERT: if (last_bit) st_nxt = S_DONE;
                S_DONE:    st_nxt = S_IDLE;
                default:   st_nxt = S_IDLE;
            endcase
        end
    end

    always_comb begin
        eoc           = 1'b0;
        sample_en     = 1'b0;
        az_phase      = 1'b0;
        cal_ofs_phase = 1'b0;
        cal_dac_phase = 1'b0;
        res_valid     = 1'b0;
        unique case (st)
            S_IDLE:      begin eoc = 1'b1; sample_en = 1'b1; end
            S_CAL_OFS:   cal_ofs_phase = 1'b1;
            S_CAL_DAC:   cal_dac_phase = 1'b1;
            S_AUTOZERO:  begin eoc = 1'b1; az_phase = 1'b1; end
            S_ACQ_TIMED: begin eoc = 1'b1; sample_en = 1'b1; end
            S_ACQ_HELD:  begin eoc = 1'b1; sample_en = 1'b1; end
            S_CONVERT:   ;
            S_DONE:      res_valid = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/adcseq_ctrl_chk.sv
module adcseq_ctrl_chk #(
    parameter int SAR_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eoc,
    input logic             sample_en,
    input logic             az_phase,
    input logic             cal_ofs_phase,
    input logic             cal_dac_phase,
    input logic [SAR_W-1:0] sar,
    input logic             res_valid
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R10
    AST_EOC_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> eoc); // R10
    AST_SAR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && $past(eoc)) |-> $stable(sar)); // R10
    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({az_phase, cal_ofs_phase, cal_dac_phase, res_valid})); // R3
    AST_CAL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_dac_phase) |-> $past(cal_ofs_phase)); // R3
    AST_EOC_LOW_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_ofs_phase || cal_dac_phase) |-> !eoc); // R2
    AST_NO_SAMPLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc |-> !sample_en); // R8
    AST_AZ_NOT_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
        az_phase |-> (eoc && !sample_en)); // R5
endmodule

bind adcseq_ctrl adcseq_ctrl_chk #(.SAR_W(SAR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eoc           (eoc),
    .sample_en     (sample_en),
    .az_phase      (az_phase),
    .cal_ofs_phase (cal_ofs_phase),
    .cal_dac_phase (cal_dac_phase),
    .sar           (sar),
    .res_valid     (res_valid)
);

// File: tb/adcseq_ctrl_tb.sv
module adcseq_ctrl_tb;
    localparam int W = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, wr_n = 1'b1, sh_n = 1'b1, cal_n = 1'b1, az_n = 1'b1;
    logic         cmp_in;
    logic         eoc, sample_en, az_phase, cal_ofs_phase, cal_dac_phase, res_valid;
    logic [W-1:0] sar;
    logic [W-1:0] vin = '0;
    int           checks = 0;
    int           errors = 0;
    bit           finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp_in = (sar <= vin);

    adcseq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .sh_n(sh_n),
        .cal_n(cal_n), .az_n(az_n), .cmp_in(cmp_in), .eoc(eoc),
        .sample_en(sample_en), .az_phase(az_phase), .cal_ofs_phase(cal_ofs_phase),
        .cal_dac_phase(cal_dac_phase), .sar(sar), .res_valid(res_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts low-eoc clocks from the current negedge; optionally disturbs with strobes.
    task automatic measure_conv(input int v, input string req, input bit disturb);
        int n = 0, seen = 0, code = -1;
        while (!eoc && n < 100) begin
            if (res_valid) begin seen++; code = int'(sar); end
            if (disturb && n == 2) begin wr_n = 1'b0; sh_n = 1'b0; end
            if (disturb && n == 4) begin wr_n = 1'b1; sh_n = 1'b1; end
            n++;
            @(negedge clk);
        end
        check(n == 14, {req, " R8 length"}, n, 14);
        check(seen == 1, {req, " R10 valid pulses"}, seen, 1);
        check(code == v, {req, " R9 result"}, code, v);
        check(eoc && !res_valid && int'(sar) == v, {req, " R10 after"}, int'(sar), v);
    endtask

    task automatic conv_sh(input int v, input int hold, input bit disturb);
        int ok = 1;
        vin = W'(v);
        @(negedge clk); cs_n = 1'b0; sh_n = 1'b0;
        repeat (hold) begin
            @(negedge clk);
            if (!(sample_en && eoc)) ok = 0;
        end
        check(ok == 1, "R7 window held", ok, 1);
        sh_n = 1'b1;
        @(negedge clk);
        measure_conv(v, disturb ? "R11" : "R7", disturb);
    endtask

    task automatic conv_wr(input int v, input bit az);
        int n = 0;
        vin = W'(v); az_n = az;
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        if (!az) begin
            while (az_phase && eoc && n < 100) begin n++; @(negedge clk); end
            check(n == 26, "R5 auto-zero length", n, 26);
            n = 0;
        end
        while (sample_en && eoc && !az_phase && n < 100) begin n++; @(negedge clk); end
        check(n == 7, az ? "R6 acquisition" : "R5 acquisition", n, 7);
        measure_conv(v, "R4", 1'b0);
        az_n = 1'b1;
    endtask

    task automatic run_cal(input bit poke);
        int n_ofs = 0, n_dac = 0, n_low = 0, rv = 0;
        cal_n = 1'b0;
        @(negedge clk); cal_n = 1'b1;
        check(int'(sar) == 0, "R2 code cleared", int'(sar), 0);
        while (!eoc && n_low < 3000) begin
            if (cal_ofs_phase) n_ofs++;
            if (cal_dac_phase) n_dac++;
            if (res_valid) rv++;
            if (poke && n_low == 300) begin cs_n = 1'b0; wr_n = 1'b0; end
            if (poke && n_low == 302) wr_n = 1'b1;
            n_low++;
            @(negedge clk);
        end
        check(n_low == 1399, poke ? "R11 cal length" : "R2 cal length", n_low, 1399);
        check(n_ofs == 199, "R3 offset phase", n_ofs, 199);
        check(n_dac == 1200, "R3 mismatch phase", n_dac, 1200);
        check(rv == 0, "R2 no result", rv, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(eoc && sample_en && !res_valid && !az_phase && !cal_ofs_phase
              && !cal_dac_phase && sar == '0, "R1 reset state", int'(sar), 0);

        run_cal(1'b0);
        conv_wr(1234, 1'b0);
        conv_wr(8191, 1'b1);
        conv_wr(0, 1'b0);

        // R4: strobes with chip select high change nothing
        begin
            int bad = 0;
            cs_n = 1'b1; az_n = 1'b0;
            @(negedge clk); wr_n = 1'b0; sh_n = 1'b0;
            @(negedge clk); wr_n = 1'b1; sh_n = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (az_phase || !eoc || !sample_en || res_valid) bad++;
            end
            check(bad == 0, "R4 deselected strobes", bad, 0);
            az_n = 1'b1;
        end

        conv_sh(4097, 1, 1'b0);
        conv_sh(2730, 9, 1'b0);
        conv_sh(5461, 3, 1'b1);

        // R2: calibration aborts a conversion in progress
        vin = W'(3000);
        @(negedge clk); cs_n = 1'b0; sh_n = 1'b0;
        @(negedge clk); sh_n = 1'b1;
        repeat (5) @(negedge clk);
        run_cal(1'b1);

        // R9: sweep of codes
        for (int v = 0; v < 8192; v += 3) conv_sh(v, 1, 1'b0);
        conv_sh(8191, 1, 1'b0);
        conv_sh(1, 2, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule